// File: doc/BRIEF.md
# Byte-Enable Access Splitter

This block sits between a 32-bit little-endian PCI data path and a 64-bit big-endian internal bus. It takes one PCI data phase, made of a data word, four active-low byte enables and the doubleword select bit of the PCI address, and turns it into internal-bus accesses. Each access is naturally aligned and has a size of one, two or four bytes.

When the enabled bytes form one unbroken run, a single access covers them. When a disabled byte sits between enabled ones, the phase becomes two accesses in strict order: the lower-addressed run goes first and the remaining bytes follow. Each access holds its request until the internal bus acknowledges it. After the final acknowledge a one-cycle completion pulse tells the PCI side that the phase has finished. A phase with no enabled byte makes no internal access and still completes.

The PCI side is expected to present a new phase only after the completion of the previous one. A request made while an earlier phase is in flight is dropped.

Top module: `be_split_top`

## Requirements
- R1: During and just after reset, `ib_req` and `done` are low.
- R2: An enable pattern with one unbroken run of enabled bytes makes exactly one access. Its size is the smallest naturally aligned container of 1, 2 or 4 bytes that covers the run, its address is the container's first byte, and `ib_lane_en` marks exactly the enabled bytes.
- R3: Gapped patterns make two accesses, the lower one first. The pairs are:
  - bytes {0,2} give {0} then {2}.
  - bytes {0,3} give {0} then {3}.
  - bytes {1,3} give {1} then {3}.
  - bytes {0,2,3} give {0} then {2,3}.
  - bytes {0,1,3} give {0,1} then {3}.
- R4: When `req_word_sel` is 1, every access address has bit 2 set and its lane enables move up by four. The split into accesses does not change.
- R5: PCI byte n (`req_data[8n+7:8n]`) has internal byte address a = 4*`req_word_sel`+n. It appears on `ib_data[63-8a -: 8]`, and every lane that is not enabled is driven to zero.
- R6: `ib_size` encodes 0 for one byte, 1 for two bytes and 2 for four bytes. `ib_addr` is aligned to that size.
- R7: An access keeps `ib_req` and all of its fields steady until `ib_ack`. The second access appears only after the first has been acknowledged.
- R8: `done` is high for exactly one cycle. That cycle is the one after the last acknowledge of the phase.
- R9: `req_be_n` = 4'b1111 makes no access, and `done` is high in the cycle after the request.
- R10: A `req_valid` made while an access is pending is ignored. It adds no access and no completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | One-cycle strobe that presents a PCI data phase |
| req_data | input | 32 | PCI data word, little-endian byte order |
| req_be_n | input | 4 | Byte enables, active low; bit n enables byte n |
| req_word_sel | input | 1 | Doubleword select (PCI address bit 2) |
| done | output | 1 | One-cycle completion of the PCI phase |
| ib_req | output | 1 | Internal-bus access request |
| ib_addr | output | 3 | Byte address of the access within the 64-bit beat |
| ib_size | output | 2 | Access size code (0:1, 1:2, 2:4 bytes) |
| ib_lane_en | output | 8 | Lanes that carry data, bit k = byte address k |
| ib_data | output | 64 | Big-endian lane data |
| ib_ack | input | 1 | Internal-bus acknowledge of the pending access |

## Verification
A bad split decision shows up in the first request cycle after the phase is taken. It appears as a wrong address, size or lane mask, or as a second access where none belongs. A state register stuck in the wrong phase shows up as a request that never drops, or as a missing or doubled completion pulse, within one cycle of the acknowledge. Lane swaps show up as misplaced bytes in `ib_data` while the request is held. A scoreboard driven by the expected access sequence catches each of these at the first access that differs.

// File: rtl/be_split_pkg.sv
// be_split_pkg: shared types for the byte-enable access splitter.
// Assumes a big-endian internal beat of twice the PCI data width.
package be_split_pkg;

    // Sequencer phase of one PCI data phase
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2
    } split_state_e;

    // Internal-bus transfer size code
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } xfer_size_e;

endpackage

// File: rtl/be_run_split.sv
// be_run_split: separates an active-high enable mask into its lowest
// unbroken run and whatever remains. Assumes at most two runs reach it
// in practice (true for four bytes); a third run would stay in the rest.
module be_run_split #(
    parameter int NB = 4
) (
    input  logic [NB-1:0] en,
    output logic [NB-1:0] low_run,
    output logic [NB-1:0] rest
);

    // Walk upward and keep bits until the first run ends
    always_comb begin
        logic started;
        logic ended;
        started = 1'b0;
        ended   = 1'b0;
        low_run = '0;
        for (int i = 0; i < NB; i++) begin
            if (en[i] && !ended) begin
                low_run[i] = 1'b1;
                started    = 1'b1;
            end else if (started) begin
                ended = 1'b1;
            end
        end
    end

    // Everything not in the first run goes to the second access
    always_comb rest = en & ~low_run;

endmodule

// File: rtl/be_container.sv
// be_container: turns one byte mask into a naturally aligned internal
// access (address, size code, lanes, big-endian data). Assumes NB = 4,
// so the largest container is one PCI word; an empty mask gives zeros.
module be_container
    import be_split_pkg::*;
#(
    parameter int NB = 4,
    localparam int IB = 2 * NB,
    localparam int AW = $clog2(IB),
    localparam int PW = 8 * NB,
    localparam int IW = 8 * IB
) (
    input  logic [NB-1:0] mask,
    input  logic          word_sel,
    input  logic [PW-1:0] pci_data,
    output logic [AW-1:0] addr,
    output logic [1:0]    size,
    output logic [IB-1:0] lanes,
    output logic [IW-1:0] data
);

    // Find the run bounds and pick the smallest aligned container
    always_comb begin
        int lo;
        int hi;
        int off;
        int base;
        lo   = 0;
        hi   = 0;
        for (int i = NB - 1; i >= 0; i--) if (mask[i]) lo = i;
        for (int i = 0; i < NB; i++)      if (mask[i]) hi = i;
        if (lo == hi) begin
            size = SZ_BYTE;
            off  = lo;
        end else if ((lo >> 1) == (hi >> 1)) begin
            size = SZ_HALF;
            off  = lo & ~1;
        end else begin
            size = SZ_WORD;
            off  = lo & ~3;
        end
        base = word_sel ? NB : 0;
        addr = AW'(base + off);
    end

    // Place each enabled PCI byte on its big-endian lane
    always_comb begin
        int a;
        lanes = '0;
        data  = '0;
        for (int b = 0; b < NB; b++) begin
            a = (word_sel ? NB : 0) + b;
            if (mask[b]) begin
                lanes[a]              = 1'b1;
                data[IW-1-8*a -: 8]   = pci_data[8*b +: 8];
            end
        end
    end

endmodule

// File: rtl/be_split_top.sv
// be_split_top: accepts one PCI data phase, runs one or two internal
// accesses with a request/acknowledge handshake, then pulses done.
// Assumes the PCI side waits for done before the next phase and that
// ib_ack is only raised while ib_req is high.
module be_split_top
    import be_split_pkg::*;
#(
    parameter int PCI_BYTES = 4,
    localparam int IB_BYTES = 2 * PCI_BYTES,
    localparam int AW = $clog2(IB_BYTES),
    localparam int PW = 8 * PCI_BYTES,
    localparam int IW = 8 * IB_BYTES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [PW-1:0]       req_data,
    input  logic [PCI_BYTES-1:0] req_be_n,
    input  logic                req_word_sel,
    output logic                done,
    output logic                ib_req,
    output logic [AW-1:0]       ib_addr,
    output logic [1:0]          ib_size,
    output logic [IB_BYTES-1:0] ib_lane_en,
    output logic [IW-1:0]       ib_data,
    input  logic                ib_ack
);

    split_state_e         state_q;
    logic [PW-1:0]        data_q;
    logic [PCI_BYTES-1:0] en_q;
    logic                 sel_q;
    logic                 done_q;

    logic [PCI_BYTES-1:0] part_mask [2];
    logic [AW-1:0]        part_addr [2];
    logic [1:0]           part_size [2];
    logic [IB_BYTES-1:0]  part_lanes[2];
    logic [IW-1:0]        part_data [2];

    be_run_split #(.NB(PCI_BYTES)) u_split (
        .en      (en_q),
        .low_run (part_mask[0]),
        .rest    (part_mask[1])
    );

    // One container per access of the phase
    for (genvar k = 0; k < 2; k++) begin : g_part
        be_container #(.NB(PCI_BYTES)) u_cont (
            .mask     (part_mask[k]),
            .word_sel (sel_q),
            .pci_data (data_q),
            .addr     (part_addr[k]),
            .size     (part_size[k]),
            .lanes    (part_lanes[k]),
            .data     (part_data[k])
        );
    end

    // Phase sequencer: capture, issue first, issue second, complete
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            data_q  <= '0;
            en_q    <= '0;
            sel_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        data_q <= req_data;
                        en_q   <= ~req_be_n;
                        sel_q  <= req_word_sel;
                        if (&req_be_n) done_q  <= 1'b1;
                        else           state_q <= ST_FIRST;
                    end
                end
                ST_FIRST: begin
                    if (ib_ack) begin
                        if (|part_mask[1]) begin
                            state_q <= ST_SECOND;
                        end else begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end
                    end
                end
                ST_SECOND: begin
                    if (ib_ack) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Drive the bus with whichever access is current
    always_comb begin
        logic second;
        second     = (state_q == ST_SECOND);
        ib_req     = (state_q != ST_IDLE);
        ib_addr    = second ? part_addr[1]  : part_addr[0];
        ib_size    = second ? part_size[1]  : part_size[0];
        ib_lane_en = second ? part_lanes[1] : part_lanes[0];
        ib_data    = second ? part_data[1]  : part_data[0];
        done       = done_q;
    end

endmodule

// File: rtl/be_split_checker.sv
// be_split_checker: protocol properties of be_split_top, bound below.
// Assumes the same parameters as the top it is bound into.
module be_split_checker #(
    parameter int PCI_BYTES = 4,
    localparam int IB_BYTES = 2 * PCI_BYTES,
    localparam int AW = $clog2(IB_BYTES),
    localparam int IW = 8 * IB_BYTES
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic [PCI_BYTES-1:0] req_be_n,
    input logic                 done,
    input logic                 ib_req,
    input logic [AW-1:0]        ib_addr,
    input logic [1:0]           ib_size,
    input logic [IB_BYTES-1:0]  ib_lane_en,
    input logic [IW-1:0]        ib_data,
    input logic                 ib_ack
);

    logic [IB_BYTES-1:0] cont_mask;
    logic [IW-1:0]       lane_bits;

    // Lanes the current container spans
    always_comb begin
        int span;
        span = 1 << ib_size;
        for (int i = 0; i < IB_BYTES; i++)
            cont_mask[i] = (i >= int'(ib_addr)) && (i < int'(ib_addr) + span);
    end

    // Bit mask of the enabled lanes
    always_comb begin
        for (int i = 0; i < IB_BYTES; i++)
            lane_bits[IW-1-8*i -: 8] = {8{ib_lane_en[i]}};
    end

    p_hold_until_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_req && !ib_ack) |=> (ib_req && $stable(ib_addr) && $stable(ib_size)
                                 && $stable(ib_lane_en) && $stable(ib_data)));

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(ib_req && ib_ack) || $past(!ib_req && req_valid && (&req_be_n))));

    p_size_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ib_req |-> (ib_size <= 2'd2 && (int'(ib_addr) % (1 << ib_size)) == 0));

    p_lanes_in_container_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ib_req |-> ((ib_lane_en & ~cont_mask) == '0 && ib_lane_en != '0));

    p_idle_lanes_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ib_req |-> ((ib_data & ~lane_bits) == '0));

    p_empty_no_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ib_req && req_valid && (&req_be_n)) |=> !ib_req);

endmodule

bind be_split_top be_split_checker #(.PCI_BYTES(PCI_BYTES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_be_n   (req_be_n),
    .done       (done),
    .ib_req     (ib_req),
    .ib_addr    (ib_addr),
    .ib_size    (ib_size),
    .ib_lane_en (ib_lane_en),
    .ib_data    (ib_data),
    .ib_ack     (ib_ack)
);

// File: tb/be_split_top_tb_top.sv
// Scoreboard bench: the driver queues expected accesses and completions,
// the monitor plays the internal bus and compares what appears.
module be_split_top_tb_top;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        is_done;
        logic [2:0]  addr;
        logic [1:0]  size;
        logic [7:0]  lanes;
        logic [63:0] data;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_data = '0;
    logic [3:0]  req_be_n = 4'hF;
    logic        req_word_sel = 1'b0;
    logic        done;
    logic        ib_req;
    logic [2:0]  ib_addr;
    logic [1:0]  ib_size;
    logic [7:0]  ib_lane_en;
    logic [63:0] ib_data;
    logic        ib_ack = 1'b0;

    int   n_checks = 0;
    int   n_fail = 0;
    int   done_seen = 0;
    int   ack_delay = 0;
    exp_t q_exp[$];
    string q_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    be_split_top dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_data(req_data),
        .req_be_n(req_be_n), .req_word_sel(req_word_sel), .done(done),
        .ib_req(ib_req), .ib_addr(ib_addr), .ib_size(ib_size),
        .ib_lane_en(ib_lane_en), .ib_data(ib_data), .ib_ack(ib_ack)
    );

    // Expected access for one byte mask, built from R2, R4, R5, R6
    function automatic exp_t mk_access(logic [3:0] m, bit sel, logic [31:0] d);
        exp_t e;
        int lo = -1, hi = -1, off, a;
        for (int b = 0; b < 4; b++) if (m[b]) begin
            if (lo < 0) lo = b;
            hi = b;
        end
        if (lo == hi)            begin e.size = 2'd0; off = lo; end
        else if (lo/2 == hi/2)   begin e.size = 2'd1; off = (lo/2)*2; end
        else                     begin e.size = 2'd2; off = 0; end
        e.is_done = 1'b0;
        e.addr  = 3'((sel ? 4 : 0) + off);
        e.lanes = '0;
        e.data  = '0;
        for (int b = 0; b < 4; b++) if (m[b]) begin
            a = (sel ? 4 : 0) + b;
            e.lanes[a] = 1'b1;
            e.data[63-8*a -: 8] = d[8*b +: 8];
        end
        return e;
    endfunction

    // Driver: queue expectations, present the phase, optionally poke while busy
    task automatic send(logic [3:0] be_n, bit sel, logic [31:0] d, bit poke, string tag);
        logic [3:0] en, m1, m2;
        exp_t dn;
        int target;
        en = ~be_n;
        case (en)   // R3 split table
            4'b0101: begin m1 = 4'b0001; m2 = 4'b0100; end
            4'b1001: begin m1 = 4'b0001; m2 = 4'b1000; end
            4'b1010: begin m1 = 4'b0010; m2 = 4'b1000; end
            4'b1101: begin m1 = 4'b0001; m2 = 4'b1100; end
            4'b1011: begin m1 = 4'b0011; m2 = 4'b1000; end
            default: begin m1 = en;      m2 = 4'b0000; end
        endcase
        if (m1 != 0) begin q_exp.push_back(mk_access(m1, sel, d)); q_tag.push_back(tag); end
        if (m2 != 0) begin q_exp.push_back(mk_access(m2, sel, d)); q_tag.push_back(tag); end
        dn = '0; dn.is_done = 1'b1;
        q_exp.push_back(dn); q_tag.push_back({tag, "/R8"});
        target = done_seen + 1;
        @(negedge clk);
        req_valid = 1'b1; req_be_n = be_n; req_word_sel = sel; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin   // R10: new phase while an access is pending
            while (!ib_req) @(negedge clk);
            req_valid = 1'b1; req_be_n = 4'b0000; req_data = ~d; req_word_sel = ~sel;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (done_seen < target) @(negedge clk);
    endtask

    // Monitor: internal-bus responder plus scoreboard compare
    initial begin
        bit fresh = 1'b1;
        int wait_cnt = 0;
        exp_t e;
        string t;
        forever begin
            @(negedge clk);
            if (!rst_n) continue;
            if (ib_ack) begin ib_ack = 1'b0; fresh = 1'b1; end
            if (done) begin
                done_seen++;
                n_checks++;
                if (q_exp.size() == 0) begin
                    n_fail++; $display("FAIL R8/R10: done with nothing expected (actual done=1 expected 0)");
                end else begin
                    e = q_exp.pop_front(); t = q_tag.pop_front();
                    if (!e.is_done) begin
                        n_fail++; $display("FAIL %s: done before access (actual done expected addr=%0d)", t, e.addr);
                    end
                end
            end
            if (ib_req && fresh) begin
                fresh = 1'b0;
                wait_cnt = ack_delay;
                n_checks++;
                if (q_exp.size() == 0) begin
                    n_fail++; $display("FAIL R10: unexpected access addr=%0d (expected none)", ib_addr);
                end else begin
                    e = q_exp.pop_front(); t = q_tag.pop_front();
                    if (e.is_done || e.addr != ib_addr || e.size != ib_size ||
                        e.lanes != ib_lane_en || e.data != ib_data) begin
                        n_fail++;
                        $display("FAIL %s: actual addr=%0d size=%0d lanes=%b data=%h expected done=%0d addr=%0d size=%0d lanes=%b data=%h",
                                 t, ib_addr, ib_size, ib_lane_en, ib_data, e.is_done, e.addr, e.size, e.lanes, e.data);
                    end
                end
            end
            if (ib_req && !fresh) begin
                if (wait_cnt == 0) ib_ack = 1'b1;
                else wait_cnt--;
            end
        end
    end

    task automatic summary;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL R8: watchdog expired (actual hang, expected completion)");
        summary();
        $finish;
    end

    // Stimulus
    initial begin
        repeat (3) @(negedge clk);
        n_checks++;   // R1
        if (ib_req !== 1'b0 || done !== 1'b0) begin
            n_fail++; $display("FAIL R1: in reset actual ib_req=%b done=%b expected 0 0", ib_req, done);
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_checks++;   // R1 after release
        if (ib_req !== 1'b0 || done !== 1'b0) begin
            n_fail++; $display("FAIL R1: after reset actual ib_req=%b done=%b expected 0 0", ib_req, done);
        end

        for (int s = 0; s < 2; s++) begin
            ack_delay = s;
            // R2 R5 R6: unbroken runs, both word halves (R4 when s=1)
            send(4'b1110, s[0], 32'hA1B2C3D4, 1'b0, "R2/R5/R6");
            send(4'b1101, s[0], 32'h11223344, 1'b0, "R2/R5");
            send(4'b1011, s[0], 32'h55667788, 1'b0, "R2/R5");
            send(4'b0111, s[0], 32'h99AABBCC, 1'b0, "R2/R5");
            send(4'b1100, s[0], 32'hDEADBEEF, 1'b0, "R2/R6");
            send(4'b0011, s[0], 32'hCAFEF00D, 1'b0, "R2/R6");
            send(4'b1001, s[0], 32'h0BADC0DE, 1'b0, "R2/R6");
            send(4'b1000, s[0], 32'h13579BDF, 1'b0, "R2/R6");
            send(4'b0001, s[0], 32'h2468ACE0, 1'b0, "R2/R6");
            send(4'b0000, s[0], 32'h0F1E2D3C, 1'b0, "R2/R4/R6");
            // R3 R7: gapped patterns, two ordered accesses
            send(4'b1010, s[0], 32'h01020304, 1'b0, "R3/R7");
            send(4'b0110, s[0], 32'h05060708, 1'b0, "R3/R7");
            send(4'b0101, s[0], 32'h090A0B0C, 1'b0, "R3/R7");
            send(4'b0010, s[0], 32'h0D0E0F10, 1'b0, "R3/R6");
            send(4'b0100, s[0], 32'h11121314, 1'b0, "R3/R4");
            // R9: nothing enabled
            send(4'b1111, s[0], 32'hFFFFFFFF, 1'b0, "R9");
        end

        // R10: request while a gapped phase is pending
        ack_delay = 3;
        send(4'b1010, 1'b0, 32'hA5A55A5A, 1'b1, "R10");
        send(4'b1100, 1'b1, 32'h3C3CC3C3, 1'b1, "R10");
        // R9 back-to-back with a real phase
        ack_delay = 0;
        send(4'b1111, 1'b1, 32'h00000000, 1'b0, "R9");
        send(4'b0100, 1'b1, 32'h77665544, 1'b0, "R3/R4");

        repeat (6) @(negedge clk);
        n_checks++;   // R10: nothing left over or extra
        if (q_exp.size() != 0 || ib_req !== 1'b0) begin
            n_fail++; $display("FAIL R10: actual pending=%0d ib_req=%b expected 0 0", q_exp.size(), ib_req);
        end
        summary();
        $finish;
    end

endmodule